// File: doc/BRIEF.md
# Interrupt Vector Relocation Address Remapper

This block is pure combinational address logic. It sits between the processor's fetch path and the flash array. On every fetch it passes the requested address through unchanged, with one exception. When the fetch is a vector fetch, relocation is allowed and the flash is only partly protected, the fetch address may fall in the interrupt-vector table at the top of the address space. In that case the block sends the read to a window of the same size that sits directly below the lowest protected address. Because of this, firmware can rewrite its interrupt vectors in the unprotected part of flash while the protected top region, including the default table, stays untouched.

The protected region is described by an enable bit and a granule number. The number gives the lowest protected address in units of 512 bytes, and the region runs from there to the top of memory. A granule number of zero with protection enabled means the whole array is protected. The two highest addresses hold the reset vector. The block never relocates them.

Top module: `vec_redirect_remap`

## Requirements
- R1: When `redir_off` is 1, `phys_addr` equals `fetch_addr` for every input combination.
- R2: When `prot_on` is 0 (no protection), `phys_addr` equals `fetch_addr`.
- R3: When `prot_on` is 1 and `prot_granule` is 0 (the whole array is protected), `phys_addr` equals `fetch_addr`.
- R4: With `redir_off`=0, `prot_on`=1, `prot_granule`≠0 and `vec_fetch`=1, a fetch in 0xFFC0..0xFFFD produces `phys_addr` = base − 0x40 + (`fetch_addr` − 0xFFC0), so the offset inside the table is kept. For example, base 0xFE00 maps 0xFFE0 to 0xFDE0.
- R5: Fetches of 0xFFFE and 0xFFFF (the reset vector) are never relocated.
- R6: Addresses outside 0xFFC0..0xFFFD pass through unchanged in every configuration.
- R7: When `vec_fetch` is 0, no relocation occurs, even inside the vector window.
- R8: The protection base equals `prot_granule` × 512, so `prot_granule` holds bits 15:9 of the lowest protected address. Example: granule 0x01 gives base 0x0200 and relocates the table to 0x01C0..0x01FD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fetch_addr | input | 16 | Address requested by the processor |
| vec_fetch | input | 1 | 1 when the current fetch is an interrupt-vector fetch |
| redir_off | input | 1 | Relocation disable option: 1 disables, 0 allows |
| prot_on | input | 1 | 1 when block protection is enabled |
| prot_granule | input | 7 | Lowest protected address in 512-byte granules |
| phys_addr | output | 16 | Address presented to the flash array |

## Verification
The assertions assume that the inputs are stable, two-state values, and they check the output only after the combinational paths have settled. The assertions also assume that the protection value is held steady by its register while a fetch is in progress. The bench supports these assumptions by changing the inputs only between samples and reading the output several nanoseconds later. It also holds every configuration input constant for the duration of each check. The bench covers the disabled, unprotected and fully protected settings. It also covers the lowest, middle and highest partial boundaries and sweeps every partial granule across the whole relocatable window.

// File: rtl/vecmap_pkg.sv
`timescale 1ns/1ps
package vecmap_pkg;
  // Classification of the protection setting
  typedef enum logic [1:0] {
    PSTATE_NONE    = 2'd0,
    PSTATE_PARTIAL = 2'd1,
    PSTATE_FULL    = 2'd2
  } prot_state_e;
endpackage

// File: rtl/prot_boundary_decode.sv
`timescale 1ns/1ps
module prot_boundary_decode
  import vecmap_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int GRAN_LOG2 = 9,
  localparam int CODE_W   = ADDR_W - GRAN_LOG2
) (
  input  logic              prot_on,
  input  logic [CODE_W-1:0] prot_granule,
  output logic [ADDR_W-1:0] prot_base,
  output prot_state_e       prot_state
);
  // Granule number -> lowest protected byte address
  function automatic logic [ADDR_W-1:0] granule_to_addr(input logic [CODE_W-1:0] code);
    return {code, {GRAN_LOG2{1'b0}}};
  endfunction

  always_comb begin
    prot_base = granule_to_addr(prot_granule);
    if (!prot_on)
      prot_state = PSTATE_NONE;
    else if (prot_granule == '0)
      prot_state = PSTATE_FULL;
    else
      prot_state = PSTATE_PARTIAL;
  end

  // R8: a partial region always starts on a nonzero granule boundary
  always_comb begin
    if (prot_state == PSTATE_PARTIAL)
      p_partial_base_aligned_r8: assert (prot_base != '0 && prot_base[GRAN_LOG2-1:0] == '0);
  end
endmodule

// File: rtl/vec_window_detect.sv
`timescale 1ns/1ps
module vec_window_detect #(
  parameter int ADDR_W   = 16,
  parameter int VEC_LOG2 = 6
) (
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              vec_fetch,
  output logic              in_window,
  output logic              is_reset_vec
);
  localparam int SPAN = 1 << VEC_LOG2;
  localparam logic [VEC_LOG2-1:0] RST_OFS = VEC_LOG2'(SPAN - 2);

  logic              top_block;
  logic [VEC_LOG2-1:0] ofs;

  always_comb begin
    top_block    = (fetch_addr[ADDR_W-1:VEC_LOG2] == '1);
    ofs          = fetch_addr[VEC_LOG2-1:0];
    is_reset_vec = top_block && (ofs >= RST_OFS);
    in_window    = vec_fetch && top_block && !is_reset_vec;
  end

  // R5: the reset vector is never part of the relocatable window
  always_comb begin
    p_window_excl_reset_r5: assert (!(in_window && is_reset_vec));
  end
endmodule

// File: rtl/vec_addr_select.sv
`timescale 1ns/1ps
module vec_addr_select
  import vecmap_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int VEC_LOG2 = 6
) (
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              in_window,
  input  logic              redir_off,
  input  prot_state_e       prot_state,
  input  logic [ADDR_W-1:0] prot_base,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              redirect_taken
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(1 << VEC_LOG2);

  // New location: window of equal size just below the protected base
  function automatic logic [ADDR_W-1:0] relocate(input logic [ADDR_W-1:0] base,
                                                 input logic [ADDR_W-1:0] addr);
    logic [ADDR_W-1:0] ofs;
    ofs = {{(ADDR_W-VEC_LOG2){1'b0}}, addr[VEC_LOG2-1:0]};
    return base - SPAN + ofs;
  endfunction

  always_comb begin
    redirect_taken = in_window && !redir_off && (prot_state == PSTATE_PARTIAL);
    phys_addr      = redirect_taken ? relocate(prot_base, fetch_addr) : fetch_addr;
  end

  // R4: a relocated read lands below the protected base with its offset kept
  always_comb begin
    if (redirect_taken) begin
      p_below_base_r4: assert (phys_addr < prot_base);
      p_offset_kept_r4: assert (phys_addr[VEC_LOG2-1:0] == fetch_addr[VEC_LOG2-1:0]);
    end
  end
endmodule

// File: rtl/vec_redirect_remap.sv
`timescale 1ns/1ps
module vec_redirect_remap
  import vecmap_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int GRAN_LOG2 = 9,
  parameter int VEC_LOG2  = 6,
  localparam int CODE_W   = ADDR_W - GRAN_LOG2
) (
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              vec_fetch,
  input  logic              redir_off,
  input  logic              prot_on,
  input  logic [CODE_W-1:0] prot_granule,
  output logic [ADDR_W-1:0] phys_addr
);
  logic [ADDR_W-1:0] prot_base;
  prot_state_e       prot_state;
  logic              in_window;
  logic              is_reset_vec;
  logic              redirect_taken;

  prot_boundary_decode #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_decode (
    .prot_on      (prot_on),
    .prot_granule (prot_granule),
    .prot_base    (prot_base),
    .prot_state   (prot_state)
  );

  vec_window_detect #(.ADDR_W(ADDR_W), .VEC_LOG2(VEC_LOG2)) u_window (
    .fetch_addr   (fetch_addr),
    .vec_fetch    (vec_fetch),
    .in_window    (in_window),
    .is_reset_vec (is_reset_vec)
  );

  vec_addr_select #(.ADDR_W(ADDR_W), .VEC_LOG2(VEC_LOG2)) u_select (
    .fetch_addr     (fetch_addr),
    .in_window      (in_window),
    .redir_off      (redir_off),
    .prot_state     (prot_state),
    .prot_base      (prot_base),
    .phys_addr      (phys_addr),
    .redirect_taken (redirect_taken)
  );

  always_comb begin
    if (redir_off)
      p_off_passthru_r1: assert (phys_addr == fetch_addr);
    if (!prot_on)
      p_noprot_passthru_r2: assert (phys_addr == fetch_addr);
    if (prot_on && prot_granule == '0)
      p_fullprot_passthru_r3: assert (phys_addr == fetch_addr);
    if (is_reset_vec)
      p_reset_fixed_r5: assert (phys_addr == fetch_addr);
    if (!in_window)
      p_outside_passthru_r6: assert (phys_addr == fetch_addr && !redirect_taken);
    if (!vec_fetch)
      p_data_passthru_r7: assert (phys_addr == fetch_addr);
  end
endmodule

// File: tb/vec_redirect_remap_bench.sv
`timescale 1ns/1ps
module vec_redirect_remap_bench;
  logic        clk = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic        vec_fetch = 1'b0;
  logic        redir_off = 1'b0;
  logic        prot_on = 1'b0;
  logic [6:0]  prot_granule = '0;
  logic [15:0] phys_addr;
  int          n_total = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  vec_redirect_remap u_vec_redirect_remap (
    .fetch_addr   (fetch_addr),
    .vec_fetch    (vec_fetch),
    .redir_off    (redir_off),
    .prot_on      (prot_on),
    .prot_granule (prot_granule),
    .phys_addr    (phys_addr)
  );

  // Independent reference: integer arithmetic on the stated rules
  function automatic int ref_phys(int a, bit vf, bit off, bit pon, int g);
    int lo_prot;
    lo_prot = g * 512;
    if (vf && !off && pon && g != 0 && a >= 'hFFC0 && a <= 'hFFFD)
      return lo_prot - 64 + (a - 'hFFC0);
    return a;
  endfunction

  task automatic apply(input int a, input bit vf, input bit off, input bit pon, input int g);
    @(negedge clk);
    fetch_addr   = 16'(a);
    vec_fetch    = vf;
    redir_off    = off;
    prot_on      = pon;
    prot_granule = 7'(g);
    #3;
  endtask

  task automatic check(input string req, input int expv);
    n_total++;
    if (int'(phys_addr) != expv) begin
      n_fail++;
      $display("FAIL %s: addr=%h got=%h exp=%h", req, fetch_addr, phys_addr, 16'(expv));
    end
  endtask

  task automatic t_reset_state();
    apply(0, 0, 0, 0, 0);
    check("R2 initial", 0);
  endtask

  task automatic t_disabled_r1();
    apply('hFFE0, 1, 1, 1, 'h7F); check("R1", 'hFFE0);
    apply('hFFC0, 1, 1, 1, 'h01); check("R1", 'hFFC0);
  endtask

  task automatic t_noprot_r2();
    apply('hFFE0, 1, 0, 0, 'h7F); check("R2", 'hFFE0);
    apply('hFFC4, 1, 0, 0, 'h10); check("R2", 'hFFC4);
  endtask

  task automatic t_fullprot_r3();
    apply('hFFE0, 1, 0, 1, 0); check("R3", 'hFFE0);
    apply('hFFFD, 1, 0, 1, 0); check("R3", 'hFFFD);
  endtask

  task automatic t_partial_r4();
    apply('hFFE0, 1, 0, 1, 'h7F); check("R4", 'hFDE0);
    apply('hFFE1, 1, 0, 1, 'h7F); check("R4", 'hFDE1);
    apply('hFFC0, 1, 0, 1, 'h7F); check("R4", 'hFDC0);
    apply('hFFFD, 1, 0, 1, 'h7F); check("R4", 'hFDFD);
    apply('hFFD2, 1, 0, 1, 'h40); check("R4", 'h7FD2);
  endtask

  task automatic t_granule_r8();
    apply('hFFC0, 1, 0, 1, 'h01); check("R8", 'h01C0);
    apply('hFFFD, 1, 0, 1, 'h01); check("R8", 'h01FD);
    apply('hFFC6, 1, 0, 1, 'h02); check("R8", 'h03C6);
  endtask

  task automatic t_reset_vec_r5();
    apply('hFFFE, 1, 0, 1, 'h7F); check("R5", 'hFFFE);
    apply('hFFFF, 1, 0, 1, 'h7F); check("R5", 'hFFFF);
    apply('hFFFE, 1, 0, 1, 'h01); check("R5", 'hFFFE);
  endtask

  task automatic t_outside_r6();
    apply('hFFBF, 1, 0, 1, 'h7F); check("R6", 'hFFBF);
    apply('h1234, 1, 0, 1, 'h7F); check("R6", 'h1234);
    apply('hFE00, 1, 0, 1, 'h7F); check("R6", 'hFE00);
  endtask

  task automatic t_data_read_r7();
    apply('hFFE0, 0, 0, 1, 'h7F); check("R7", 'hFFE0);
    apply('hFFC0, 0, 0, 1, 'h01); check("R7", 'hFFC0);
  endtask

  task automatic t_sweep_r4();
    for (int g = 1; g < 128; g++) begin
      for (int o = 0; o < 64; o += 7) begin
        apply('hFFC0 + o, 1, 0, 1, g);
        check("R4 sweep", ref_phys('hFFC0 + o, 1, 0, 1, g));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: got=hung exp=finished");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_disabled_r1();
    t_noprot_r2();
    t_fullprot_r3();
    t_partial_r4();
    t_granule_r8();
    t_reset_vec_r5();
    t_outside_r6();
    t_data_read_r7();
    t_sweep_r4();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule